// File: doc/BRIEF.md
# ATA Device Interrupt Request Controller

This block produces the interrupt line that a parallel-ATA device presents to its host. A pending flag is raised by one-cycle event pulses from the device core, for example command completion or a sector becoming ready. The flag is cleared by the host acknowledging in one of the recognised ways: writing the command register, reading the status register, or a sector data transfer finishing. A software reset held in the control register also clears it, and so does the active-low hardware reset.

The pin level follows the pending flag only while the pin is enabled. The enable is true when this device is selected and the interrupt-disable bit is clear. The pad tri-states the pin whenever the enable is low. When the pin is not enabled the pending flag is kept, so re-selecting the device or re-enabling interrupts shows an interrupt that is still outstanding. Register decoding, command execution and the pad are outside this block.

Top module: `ata_intrq_ctrl`

## Requirements
- R1: While `hw_rst_n` is low the pending flag is cleared asynchronously, without waiting for a clock edge, and `intrq_o` reads 0.
- R2: A 1 on any bit of `evt_set` at a rising clock edge, with `srst` low, makes the flag pending after that edge.
- R3: A `cmd_wr` pulse with no event in the same cycle clears the pending flag after the edge.
- R4: A `stat_rd` pulse with no event in the same cycle clears the pending flag after the edge.
- R5: A `xfer_done` pulse with no event in the same cycle clears the pending flag after the edge. No status read is needed.
- R6: While `srst` is 1 the flag is cleared and stays cleared, even when events arrive.
- R7: When an event and a host clear pulse (`cmd_wr`, `stat_rd` or `xfer_done`) arrive in the same cycle, the flag ends up pending.
- R8: `intrq_oe` equals `dev_sel` AND NOT `nien` for all four combinations of these inputs, combinationally.
- R9: `intrq_o` is 1 exactly when the flag is pending and `intrq_oe` is 1. It is 0 otherwise.
- R10: Dropping `intrq_oe` does not clear the pending flag. The interrupt reappears on `intrq_o` once the pin is enabled again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| hw_rst_n | input | 1 | Hardware reset, active low, asynchronous |
| evt_set | input | N_EVT | One-cycle interrupt event pulses from the device core |
| cmd_wr | input | 1 | Decoded host write to the command register (pulse) |
| stat_rd | input | 1 | Decoded host read of the status register (pulse) |
| xfer_done | input | 1 | Sector data transfer completed (pulse) |
| srst | input | 1 | Software reset bit of the device control register (level) |
| nien | input | 1 | Interrupt-disable bit of the device control register (level) |
| dev_sel | input | 1 | This device is currently selected |
| intrq_o | output | 1 | Interrupt level toward the pad |
| intrq_oe | output | 1 | Pad output enable. The pin floats when this is 0 |

## Verification
Each clear source is applied on its own after a fresh event, so that a design that ignores any one of them is exposed. The same sources are then applied together with an event, which separates set-wins priority from clear-wins priority. Software reset is held across incoming events to tell a level-sensitive clear from a pulse clear. The select and interrupt-disable inputs are swept through all four combinations, with the flag both pending and idle. A hardware reset is asserted between clock edges to show that the clear does not wait for a clock edge.

// File: rtl/ata_irq_pkg.sv
package ata_irq_pkg;

  // Host acknowledgements that retire a pending interrupt.
  typedef struct packed {
    logic cmd_wr;
    logic stat_rd;
    logic xfer_done;
  } host_clr_t;

  localparam int unsigned HOST_CLR_W = $bits(host_clr_t);

  // Next state of the pending flag: software reset dominates, then a new
  // event, then any host acknowledgement.
  function automatic logic next_pending(input logic cur, input logic set_any,
                                        input logic clr_any, input logic sw_rst);
    logic nxt;
    if (sw_rst)       nxt = 1'b0;
    else if (set_any) nxt = 1'b1;
    else if (clr_any) nxt = 1'b0;
    else              nxt = cur;
    return nxt;
  endfunction

  function automatic logic pin_enable(input logic sel, input logic dis);
    return sel & ~dis;
  endfunction

  function automatic logic pin_level(input logic pend, input logic en);
    return pend & en;
  endfunction

endpackage

// File: rtl/irq_event_merge.sv
module irq_event_merge
  import ata_irq_pkg::*;
#(
  parameter int unsigned N_EVT = 2
) (
  input  logic [N_EVT-1:0] evt_set,
  input  host_clr_t        host_clr,
  output logic             set_any,
  output logic             clr_any
);

  localparam int unsigned CLR_W = HOST_CLR_W;

  logic [N_EVT-1:0] set_chain;
  logic [CLR_W-1:0] clr_vec;

  assign clr_vec = host_clr;

  // Explicit OR chain over the event sources.
  generate
    genvar gi;
    for (gi = 0; gi < N_EVT; gi++) begin : g_set
      if (gi == 0) begin : g_first
        assign set_chain[gi] = evt_set[gi];
      end else begin : g_rest
        assign set_chain[gi] = set_chain[gi-1] | evt_set[gi];
      end
    end
  endgenerate

  assign set_any = set_chain[N_EVT-1];
  assign clr_any = |clr_vec;

endmodule

// File: rtl/irq_pending_flag.sv
module irq_pending_flag
  import ata_irq_pkg::*;
(
  input  logic clk,
  input  logic hw_rst_n,
  input  logic set_any,
  input  logic clr_any,
  input  logic srst,
  output logic pending
);

  logic pend_q;
  logic pend_d;

  always_comb pend_d = next_pending(pend_q, set_any, clr_any, srst);

  always_ff @(posedge clk or negedge hw_rst_n) begin
    if (!hw_rst_n) pend_q <= 1'b0;
    else           pend_q <= pend_d;
  end

  assign pending = pend_q;

  // R1: flag is clear at every edge seen while reset is low
  a_r1_reset_clear: assert property (@(posedge clk) !hw_rst_n |-> !pend_q);

  // R2 / R7: an event with software reset low always leaves the flag set
  a_r2_event_sets: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (set_any && !srst) |=> pend_q);

  // R6: software reset leaves the flag clear
  a_r6_srst_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
    srst |=> !pend_q);

  // R10: with no clear source the flag holds its value
  a_r10_hold: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (pend_q && !clr_any && !srst) |=> pend_q);

endmodule

// File: rtl/irq_pin_drive.sv
module irq_pin_drive
  import ata_irq_pkg::*;
(
  input  logic pending,
  input  logic dev_sel,
  input  logic nien,
  output logic intrq_o,
  output logic intrq_oe
);

  logic en;

  always_comb begin
    en       = pin_enable(dev_sel, nien);
    intrq_oe = en;
    intrq_o  = pin_level(pending, en);
  end

endmodule

// File: rtl/ata_intrq_ctrl.sv
module ata_intrq_ctrl
  import ata_irq_pkg::*;
#(
  parameter int unsigned N_EVT = 2
) (
  input  logic             clk,
  input  logic             hw_rst_n,
  input  logic [N_EVT-1:0] evt_set,
  input  logic             cmd_wr,
  input  logic             stat_rd,
  input  logic             xfer_done,
  input  logic             srst,
  input  logic             nien,
  input  logic             dev_sel,
  output logic             intrq_o,
  output logic             intrq_oe
);

  host_clr_t host_clr;
  logic      set_any;
  logic      clr_any;
  logic      pending;

  always_comb begin
    host_clr.cmd_wr    = cmd_wr;
    host_clr.stat_rd   = stat_rd;
    host_clr.xfer_done = xfer_done;
  end

  irq_event_merge #(.N_EVT(N_EVT)) u_merge (
    .evt_set  (evt_set),
    .host_clr (host_clr),
    .set_any  (set_any),
    .clr_any  (clr_any)
  );

  irq_pending_flag u_flag (
    .clk      (clk),
    .hw_rst_n (hw_rst_n),
    .set_any  (set_any),
    .clr_any  (clr_any),
    .srst     (srst),
    .pending  (pending)
  );

  irq_pin_drive u_pin (
    .pending  (pending),
    .dev_sel  (dev_sel),
    .nien     (nien),
    .intrq_o  (intrq_o),
    .intrq_oe (intrq_oe)
  );

  // R3: command write alone retires the interrupt
  a_r3_cmd_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (cmd_wr && !(|evt_set)) |=> !pending);

  // R4: status read alone retires the interrupt
  a_r4_stat_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (stat_rd && !(|evt_set)) |=> !pending);

  // R5: transfer completion alone retires the interrupt
  a_r5_xfer_clear: assert property (@(posedge clk) disable iff (!hw_rst_n)
    (xfer_done && !(|evt_set)) |=> !pending);

  // R7: event beats a simultaneous host clear
  a_r7_set_wins: assert property (@(posedge clk) disable iff (!hw_rst_n)
    ((|evt_set) && (cmd_wr || stat_rd || xfer_done) && !srst) |=> intrq_o == intrq_oe);

  // R9: a high pin level is only possible when the pin is enabled by the port inputs
  a_r9_level_needs_enable: assert property (@(posedge clk) disable iff (!hw_rst_n)
    intrq_o |-> (dev_sel && !nien));

endmodule

// File: tb/sim_ata_intrq_ctrl.sv
`timescale 1ns/1ps
module sim_ata_intrq_ctrl;

  localparam int unsigned N_EVT = 2;

  logic             clk = 1'b0;
  logic             hw_rst_n = 1'b0;
  logic [N_EVT-1:0] evt_set = '0;
  logic             cmd_wr = 1'b0, stat_rd = 1'b0, xfer_done = 1'b0;
  logic             srst = 1'b0, nien = 1'b0, dev_sel = 1'b1;
  logic             intrq_o, intrq_oe;

  int n_cmp = 0;
  int n_bad = 0;
  bit ref_pend = 1'b0;

  always #2 clk = ~clk;

  ata_intrq_ctrl #(.N_EVT(N_EVT)) u0 (
    .clk(clk), .hw_rst_n(hw_rst_n), .evt_set(evt_set), .cmd_wr(cmd_wr),
    .stat_rd(stat_rd), .xfer_done(xfer_done), .srst(srst), .nien(nien),
    .dev_sel(dev_sel), .intrq_o(intrq_o), .intrq_oe(intrq_oe)
  );

  // Reference model: what the requirements say happens at each edge.
  always @(posedge clk or negedge hw_rst_n) begin
    if (hw_rst_n == 1'b0) ref_pend <= 1'b0;
    else begin
      int ev;
      int ack;
      ev  = 0;
      ack = 0;
      for (int i = 0; i < N_EVT; i++) if (evt_set[i]) ev++;
      if (cmd_wr) ack++;
      if (stat_rd) ack++;
      if (xfer_done) ack++;
      if (srst)        ref_pend <= 1'b0;
      else if (ev > 0) ref_pend <= 1'b1;
      else if (ack > 0) ref_pend <= 1'b0;
    end
  end

  task automatic chk(input string req, input logic act, input logic exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%b expected=%b at %0t", req, act, exp, $time);
    end
  endtask

  // Every-cycle comparison against the model, away from the rising edge.
  always @(negedge clk) begin
    bit en;
    en = dev_sel && !nien;
    chk("R8 oe", intrq_oe, en);
    chk("R9 level", intrq_o, ref_pend && en && hw_rst_n);
  end

  // Apply pulses for one edge, then drop them.
  task automatic pulse(input logic [N_EVT-1:0] ev, input logic cw,
                       input logic sr, input logic xd);
    evt_set = ev; cmd_wr = cw; stat_rd = sr; xfer_done = xd;
    @(posedge clk); #1;
    evt_set = '0; cmd_wr = 1'b0; stat_rd = 1'b0; xfer_done = 1'b0;
  endtask

  task automatic look(input string req, input logic exp);
    @(negedge clk);
    chk(req, intrq_o, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        chk("R1 reset pin", intrq_o, 1'b0);
        chk("R1 reset oe", intrq_oe, 1'b1);
        @(posedge clk); #1;
        hw_rst_n = 1'b1;
        @(posedge clk); #1;

        pulse(2'b01, 0, 0, 0); look("R2 set evt0", 1'b1);
        pulse(2'b00, 1, 0, 0); look("R3 cmd_wr clear", 1'b0);
        pulse(2'b10, 0, 0, 0); look("R2 set evt1", 1'b1);
        pulse(2'b00, 0, 1, 0); look("R4 stat_rd clear", 1'b0);
        pulse(2'b01, 0, 0, 0); look("R2 set", 1'b1);
        pulse(2'b00, 0, 0, 1); look("R5 xfer_done clear", 1'b0);

        pulse(2'b01, 0, 0, 0); look("R2 set", 1'b1);
        srst = 1'b1;
        @(posedge clk); #1;
        look("R6 srst clear", 1'b0);
        pulse(2'b11, 0, 0, 0); look("R6 srst held vs event", 1'b0);
        srst = 1'b0;
        @(posedge clk); #1;
        look("R6 stays clear after release", 1'b0);

        pulse(2'b01, 1, 0, 0); look("R7 event+cmd_wr", 1'b1);
        pulse(2'b00, 0, 1, 0); look("R4 clear", 1'b0);
        pulse(2'b10, 0, 1, 0); look("R7 event+stat_rd", 1'b1);
        pulse(2'b00, 1, 0, 0); look("R3 clear", 1'b0);
        pulse(2'b01, 0, 0, 1); look("R7 event+xfer_done", 1'b1);

        dev_sel = 1'b0;
        look("R9 deselected low", 1'b0);
        dev_sel = 1'b1;
        look("R10 reappears after reselect", 1'b1);
        nien = 1'b1;
        look("R9 disabled low", 1'b0);
        nien = 1'b0;
        look("R10 reappears after enable", 1'b1);

        for (int p = 0; p < 2; p++) begin
          if (p == 1) pulse(2'b00, 0, 1, 0);
          for (int c = 0; c < 4; c++) begin
            dev_sel = c[0];
            nien    = c[1];
            #0.5;
            chk("R8 oe combo", intrq_oe, c[0] && !c[1]);
            chk("R9 level combo", intrq_o, (p == 0) && c[0] && !c[1]);
            @(posedge clk); #1;
          end
        end
        dev_sel = 1'b1; nien = 1'b0;

        pulse(2'b01, 0, 0, 0); look("R2 set", 1'b1);
        #0.5 hw_rst_n = 1'b0;
        #0.5 chk("R1 async clear", intrq_o, 1'b0);
        @(posedge clk); #1;
        hw_rst_n = 1'b1;
        look("R1 clear after release", 1'b0);
        repeat (3) @(posedge clk);
      end
      begin
        repeat (5000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
      end
    join_any
    disable fork;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule